// File: doc/BRIEF.md
# Instruction Tracking List with Rollback

This block keeps the program order of every instruction in flight in a 32-slot circular list. The list is built from four banks of eight rows each, and the slot index doubles as the instruction's 5-bit tag. Decode appends up to four instructions per cycle. For each one it records whether it writes a register, its logical destination and the physical register that the destination pointed to before renaming. Execution units report a finished instruction by its tag, and that sets the slot's finished flag. The oldest finished instructions leave the list from the head, up to four per cycle, in order. Each one that had a destination hands its previous physical register back for reuse.

Two recovery paths are provided. The first is an exception on a tagged instruction. The list then enters a rollback walk that replays the recorded mappings from the youngest entry down to the faulting one, one per cycle, so that the rename map can be rebuilt. The second is a branch misprediction. The tail is cut back in a single cycle to the slot just after the branch.

The controller has two states. RUN is the reset state: it allocates, retires and accepts recovery events. UNDO performs the rollback walk. The transition RUN→UNDO is taken when an exception is presented. The transition UNDO→RUN is taken in the cycle the walk emits the faulting entry. Otherwise RUN→RUN and UNDO→UNDO hold.

Top module: `active_list`

## Requirements
- R1: After reset the list is empty: `alloc_ok` is 1, `alloc_tag` is 0, and `grad_mask`, `free_valid` and `undo_valid` are all 0.
- R2: When `alloc_ok` is 1 and `alloc_n` (0 to 4) is non-zero, lane i (bits `i*5` of `alloc_lreg`, `i*6` of `alloc_oldp`) is written to tag `alloc_tag+i` mod 32. `alloc_tag` then advances by `alloc_n`.
- R3: `alloc_ok` is 0 when fewer than 4 slots are free, in UNDO, or while `exc_valid` or `br_valid` is high. A request made while `alloc_ok` is 0 leaves the list unchanged.
- R4: `cmpl_valid` with `cmpl_tag` marks that entry finished. `grad_mask` bit i means the entry at head+i retires this cycle. The mask is a prefix that covers at most 4 entries, never passes the tail, and stops at the first unfinished entry.
- R5: `free_valid[i]` equals `grad_mask[i]` AND that entry's destination flag. `free_preg` bits `i*6+5:i*6` carry the entry's recorded previous physical register.
- R6: In the cycle `exc_valid` is high, nothing retires. In UNDO, entries are emitted one per cycle from the youngest down to and including `exc_tag`. `undo_valid` is 1 only for entries with a destination and shows their `undo_lreg` and `undo_preg`. `alloc_ok` stays 0 throughout.
- R7: After the walk, the tail equals the faulting tag, so `alloc_tag` equals `exc_tag`. The rolled-back entries never retire.
- R8: `br_valid` with `br_tag` sets the tail to `br_tag+1` in one cycle. In that cycle nothing retires and nothing is allocated.
- R9: During UNDO, `exc_valid` and `br_valid` are ignored and nothing retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_n | input | 3 | Number of instructions to append (0..4) |
| alloc_has_dst | input | 4 | Per-lane: instruction writes a register |
| alloc_lreg | input | 20 | Per-lane logical destination, 5 bits each |
| alloc_oldp | input | 24 | Per-lane previous physical register, 6 bits each |
| alloc_ok | output | 1 | Room for a full group and no recovery in progress |
| alloc_tag | output | 5 | Tag given to lane 0 of the next group |
| cmpl_valid | input | 1 | Completion report valid |
| cmpl_tag | input | 5 | Tag of the completed instruction |
| grad_mask | output | 4 | Entries head+i retiring this cycle |
| free_valid | output | 4 | Retiring entry returns a physical register |
| free_preg | output | 24 | Returned physical registers, 6 bits each |
| exc_valid | input | 1 | Exception on a listed instruction |
| exc_tag | input | 5 | Tag of the faulting instruction |
| br_valid | input | 1 | Branch misprediction |
| br_tag | input | 5 | Tag of the mispredicted branch |
| undo_valid | output | 1 | Rollback mapping valid |
| undo_lreg | output | 5 | Logical register to restore |
| undo_preg | output | 6 | Physical register to restore it to |

## Verification
The hardest condition to reach is a rollback walk across the wrap of the circular index while recovery inputs keep arriving. The stimulus first drains earlier groups so that the head moves to slot 20. It then fills the list to 29 entries so that the tail wraps past slot 31. The exception lands on slot 13, and a branch and a second exception are driven in the middle of the walk to confirm that both are ignored. The bench then completes every surviving entry and counts retirements to show that exactly the older 25 leave.

// File: rtl/al_pkg.sv
package al_pkg;

    localparam int AL_LREG_W = 5;
    localparam int AL_PREG_W = 6;

    // Fields read at retirement.
    typedef struct packed {
        logic                 has_dst;
        logic [AL_PREG_W-1:0] oldp;
    } al_free_t;

    // Full record of one entry.
    typedef struct packed {
        logic                 has_dst;
        logic [AL_LREG_W-1:0] lreg;
        logic [AL_PREG_W-1:0] oldp;
    } al_entry_t;

    typedef enum logic [0:0] {
        S_RUN  = 1'b0,
        S_UNDO = 1'b1
    } al_state_e;

endpackage

// File: rtl/al_store.sv
module al_store
    import al_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int ROWS  = 8,
    localparam int SLOTS = LANES * ROWS,
    localparam int TAG_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            wr_n,
    input  logic [TAG_W-1:0]            wr_base,
    input  al_entry_t [LANES-1:0]       wr_ent,
    input  logic                        set_en,
    input  logic [TAG_W-1:0]            set_tag,
    input  logic [TAG_W-1:0]            rd_base,
    output al_free_t  [LANES-1:0]       rd_ent,
    output logic      [LANES-1:0]       rd_done,
    input  logic [TAG_W-1:0]            undo_addr,
    output al_entry_t                   undo_ent
);

    localparam int LANE_W = $clog2(LANES);

    logic [SLOTS-1:0]        done_q;
    al_free_t  [LANES-1:0]   lane_rd;
    al_entry_t [LANES-1:0]   lane_undo;

    // One bank per lane; consecutive tags rotate across banks.
    for (genvar l = 0; l < LANES; l++) begin : g_bank
        al_free_t         free_q [ROWS];
        logic [AL_LREG_W-1:0] lreg_q [ROWS];
        logic [LANE_W-1:0] wr_slot, rd_slot;
        logic [TAG_W-1:0]  wr_tag, rd_tag;

        assign wr_slot = LANE_W'(l) - wr_base[LANE_W-1:0];
        assign wr_tag  = wr_base + TAG_W'(wr_slot);
        assign rd_slot = LANE_W'(l) - rd_base[LANE_W-1:0];
        assign rd_tag  = rd_base + TAG_W'(rd_slot);

        always_ff @(posedge clk) begin
            if (CNT_W'(wr_slot) < wr_n) begin
                free_q[wr_tag[TAG_W-1:LANE_W]] <= '{has_dst: wr_ent[wr_slot].has_dst,
                                                   oldp:    wr_ent[wr_slot].oldp};
                lreg_q[wr_tag[TAG_W-1:LANE_W]] <= wr_ent[wr_slot].lreg;
            end
        end

        assign lane_rd[l] = free_q[rd_tag[TAG_W-1:LANE_W]];
        assign lane_undo[l] = '{has_dst: free_q[undo_addr[TAG_W-1:LANE_W]].has_dst,
                                lreg:    lreg_q[undo_addr[TAG_W-1:LANE_W]],
                                oldp:    free_q[undo_addr[TAG_W-1:LANE_W]].oldp};
    end

    always_comb begin
        logic [TAG_W-1:0] t;
        for (int k = 0; k < LANES; k++) begin
            t          = rd_base + TAG_W'(k);
            rd_ent[k]  = lane_rd[t[LANE_W-1:0]];
            rd_done[k] = done_q[t];
        end
    end

    assign undo_ent = lane_undo[undo_addr[LANE_W-1:0]];

    // Finished flags: cleared on allocation, set on completion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (CNT_W'(k) < wr_n) done_q[wr_base + TAG_W'(k)] <= 1'b0;
            end
            if (set_en) done_q[set_tag] <= 1'b1;
        end
    end

endmodule

// File: rtl/al_grad.sv
module al_grad #(
    parameter int LANES = 4,
    parameter int PTR_W = 6
) (
    input  logic             en,
    input  logic [PTR_W-1:0] avail,
    input  logic [LANES-1:0] done,
    output logic [LANES-1:0] mask
);

    // In-order prefix: stop at the first unfinished or absent entry.
    always_comb begin
        logic run;
        run = en;
        for (int k = 0; k < LANES; k++) begin
            run     = run && done[k] && (PTR_W'(k) < avail);
            mask[k] = run;
        end
    end

endmodule

// File: rtl/active_list.sv
module active_list
    import al_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int ROWS  = 8,
    localparam int SLOTS = LANES * ROWS,
    localparam int TAG_W = $clog2(SLOTS),
    localparam int PTR_W = TAG_W + 1,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             alloc_n,
    input  logic [LANES-1:0]             alloc_has_dst,
    input  logic [LANES*AL_LREG_W-1:0]   alloc_lreg,
    input  logic [LANES*AL_PREG_W-1:0]   alloc_oldp,
    output logic                         alloc_ok,
    output logic [TAG_W-1:0]             alloc_tag,
    input  logic                         cmpl_valid,
    input  logic [TAG_W-1:0]             cmpl_tag,
    output logic [LANES-1:0]             grad_mask,
    output logic [LANES-1:0]             free_valid,
    output logic [LANES*AL_PREG_W-1:0]   free_preg,
    input  logic                         exc_valid,
    input  logic [TAG_W-1:0]             exc_tag,
    input  logic                         br_valid,
    input  logic [TAG_W-1:0]             br_tag,
    output logic                         undo_valid,
    output logic [AL_LREG_W-1:0]         undo_lreg,
    output logic [AL_PREG_W-1:0]         undo_preg
);

    al_state_e        state_q, state_d;
    logic [PTR_W-1:0] head_q, tail_q, walk_q;
    logic [TAG_W-1:0] fault_q;

    logic [PTR_W-1:0] used, room, nret, br_keep;
    logic             in_run, alloc_go, ret_en, walk_last;

    al_entry_t [LANES-1:0] wr_ent;
    al_free_t  [LANES-1:0] rd_ent;
    logic      [LANES-1:0] rd_done;
    al_entry_t             undo_ent;

    assign used      = tail_q - head_q;
    assign room      = PTR_W'(SLOTS) - used;
    assign in_run    = (state_q == S_RUN);
    assign alloc_ok  = in_run && !exc_valid && !br_valid && (room >= PTR_W'(LANES));
    assign alloc_go  = alloc_ok && (alloc_n != '0);
    assign ret_en    = in_run && !exc_valid && !br_valid;
    assign walk_last = (walk_q[TAG_W-1:0] == fault_q);
    assign br_keep   = PTR_W'(TAG_W'(br_tag - head_q[TAG_W-1:0])) + PTR_W'(1);
    assign nret      = PTR_W'($countones(grad_mask));

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            wr_ent[i] = '{has_dst: alloc_has_dst[i],
                          lreg:    alloc_lreg[i*AL_LREG_W +: AL_LREG_W],
                          oldp:    alloc_oldp[i*AL_PREG_W +: AL_PREG_W]};
        end
    end

    al_store #(.LANES(LANES), .ROWS(ROWS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n      (alloc_go ? alloc_n : '0),
        .wr_base   (tail_q[TAG_W-1:0]),
        .wr_ent    (wr_ent),
        .set_en    (cmpl_valid),
        .set_tag   (cmpl_tag),
        .rd_base   (head_q[TAG_W-1:0]),
        .rd_ent    (rd_ent),
        .rd_done   (rd_done),
        .undo_addr (walk_q[TAG_W-1:0]),
        .undo_ent  (undo_ent)
    );

    al_grad #(.LANES(LANES), .PTR_W(PTR_W)) u_grad (
        .en    (ret_en),
        .avail (used),
        .done  (rd_done),
        .mask  (grad_mask)
    );

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  if (exc_valid) state_d = S_UNDO;
            S_UNDO: if (walk_last) state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    // State and pointer registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            head_q  <= '0;
            tail_q  <= '0;
            walk_q  <= '0;
            fault_q <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_q + nret;
            unique case (state_q)
                S_RUN: begin
                    if (exc_valid) begin
                        walk_q  <= tail_q - PTR_W'(1);
                        fault_q <= exc_tag;
                    end else if (br_valid) begin
                        tail_q <= head_q + br_keep;
                    end else if (alloc_go) begin
                        tail_q <= tail_q + PTR_W'(alloc_n);
                    end
                end
                S_UNDO: begin
                    if (walk_last) tail_q <= walk_q;
                    else           walk_q <= walk_q - PTR_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        alloc_tag  = tail_q[TAG_W-1:0];
        undo_valid = (state_q == S_UNDO) && undo_ent.has_dst;
        undo_lreg  = undo_ent.lreg;
        undo_preg  = undo_ent.oldp;
        for (int i = 0; i < LANES; i++) begin
            free_valid[i]                      = grad_mask[i] && rd_ent[i].has_dst;
            free_preg[i*AL_PREG_W +: AL_PREG_W] = rd_ent[i].oldp;
        end
    end

endmodule

// File: rtl/al_check.sv
module al_check #(
    parameter int LANES = 4,
    parameter int TAG_W = 5,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] alloc_n,
    input logic             alloc_ok,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             exc_valid,
    input logic             br_valid,
    input logic [LANES-1:0] grad_mask,
    input logic [LANES-1:0] free_valid,
    input logic             undo_valid
);

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && alloc_n != '0) |=> alloc_tag == TAG_W'($past(alloc_tag) + TAG_W'($past(alloc_n))));

    assert_grad_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grad_mask & LANES'(grad_mask + 1'b1)) == '0);

    assert_free_within_grad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid & ~grad_mask) == '0);

    assert_exc_no_grad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> grad_mask == '0);

    assert_undo_blocks_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        undo_valid |-> !alloc_ok);

    assert_br_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (grad_mask == '0 && !alloc_ok));

endmodule

bind active_list al_check #(.LANES(LANES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_al_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_n    (alloc_n),
    .alloc_ok   (alloc_ok),
    .alloc_tag  (alloc_tag),
    .exc_valid  (exc_valid),
    .br_valid   (br_valid),
    .grad_mask  (grad_mask),
    .free_valid (free_valid),
    .undo_valid (undo_valid)
);

// File: tb/active_list_test.sv
`timescale 1ns/1ps
module active_list_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  alloc_n;
    logic [3:0]  alloc_has_dst;
    logic [19:0] alloc_lreg;
    logic [23:0] alloc_oldp;
    logic        alloc_ok;
    logic [4:0]  alloc_tag;
    logic        cmpl_valid;
    logic [4:0]  cmpl_tag;
    logic [3:0]  grad_mask, free_valid;
    logic [23:0] free_preg;
    logic        exc_valid, br_valid;
    logic [4:0]  exc_tag, br_tag;
    logic        undo_valid;
    logic [4:0]  undo_lreg;
    logic [5:0]  undo_preg;

    always #2.5 clk = ~clk;

    active_list uut (
        .clk(clk), .rst_n(rst_n), .alloc_n(alloc_n), .alloc_has_dst(alloc_has_dst),
        .alloc_lreg(alloc_lreg), .alloc_oldp(alloc_oldp), .alloc_ok(alloc_ok),
        .alloc_tag(alloc_tag), .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .grad_mask(grad_mask), .free_valid(free_valid), .free_preg(free_preg),
        .exc_valid(exc_valid), .exc_tag(exc_tag), .br_valid(br_valid), .br_tag(br_tag),
        .undo_valid(undo_valid), .undo_lreg(undo_lreg), .undo_preg(undo_preg)
    );

    // {has_dst, lreg[4:0], oldp[5:0]} for tags 0..15
    localparam logic [11:0] TBL [16] = '{
        {1'b1, 5'd3,  6'd40}, {1'b0, 5'd0,  6'd0},  {1'b1, 5'd7,  6'd33}, {1'b1, 5'd31, 6'd63},
        {1'b1, 5'd1,  6'd12}, {1'b1, 5'd2,  6'd13}, {1'b0, 5'd9,  6'd21}, {1'b1, 5'd4,  6'd50},
        {1'b0, 5'd5,  6'd5},  {1'b1, 5'd6,  6'd44}, {1'b1, 5'd8,  6'd1},  {1'b0, 5'd10, 6'd2},
        {1'b1, 5'd11, 6'd37}, {1'b1, 5'd12, 6'd38}, {1'b1, 5'd13, 6'd39}, {1'b0, 5'd14, 6'd62}
    };

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit f_hd(input int t);
        return (t % 3) != 0;
    endfunction
    function automatic logic [4:0] f_lr(input int t);
        return 5'((t * 3) & 31);
    endfunction
    function automatic logic [5:0] f_op(input int t);
        return 6'((t * 5 + 1) & 63);
    endfunction

    task automatic clear_in();
        alloc_n = '0; alloc_has_dst = '0; alloc_lreg = '0; alloc_oldp = '0;
        cmpl_valid = 1'b0; cmpl_tag = '0; exc_valid = 1'b0; exc_tag = '0;
        br_valid = 1'b0; br_tag = '0;
    endtask

    task automatic set_lane(input int i, input bit h, input logic [4:0] l, input logic [5:0] p);
        alloc_has_dst[i]   = h;
        alloc_lreg[i*5 +: 5] = l;
        alloc_oldp[i*6 +: 6] = p;
    endtask

    // Append n instructions whose data derive from their tags.
    task automatic alloc_fn(input int n, input int t0);
        @(negedge clk); clear_in();
        alloc_n = 3'(n);
        for (int i = 0; i < n; i++) set_lane(i, f_hd((t0 + i) % 32), f_lr((t0 + i) % 32), f_op((t0 + i) % 32));
        #1;
        chk(alloc_ok == 1'b1 && alloc_tag == 5'(t0), "R2 group tag", alloc_tag, t0);
    endtask

    task automatic complete(input int t, input logic [3:0] exp_grad, input string req);
        @(negedge clk); clear_in();
        cmpl_valid = 1'b1; cmpl_tag = 5'(t);
        #1;
        chk(grad_mask == exp_grad, req, grad_mask, exp_grad);
    endtask

    task automatic idle_grad(input logic [3:0] exp_grad, input string req);
        @(negedge clk); clear_in();
        #1;
        chk(grad_mask == exp_grad, req, grad_mask, exp_grad);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nvec++; nbad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int sum;
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(alloc_ok == 1'b1 && alloc_tag == 5'd0, "R1 empty after reset", {alloc_ok, alloc_tag}, 6'h20);
        chk(grad_mask == '0 && free_valid == '0 && undo_valid == 1'b0, "R1 outputs idle",
            {grad_mask, free_valid, undo_valid}, 0);

        // Vector table: four full groups, then completions youngest first.
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); clear_in();
            alloc_n = 3'd4;
            for (int i = 0; i < 4; i++)
                set_lane(i, TBL[4*c+i][11], TBL[4*c+i][10:6], TBL[4*c+i][5:0]);
            #1;
            chk(alloc_ok == 1'b1 && alloc_tag == 5'(4*c), "R2 table tag", alloc_tag, 4*c);
        end
        for (int t = 15; t >= 0; t--) complete(t, 4'b0000, "R4 oldest unfinished blocks");
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); clear_in();
            #1;
            chk(grad_mask == 4'hf, "R4 four per cycle", grad_mask, 4'hf);
            for (int i = 0; i < 4; i++) begin
                chk(free_valid[i] == TBL[4*c+i][11], "R5 free flag", free_valid[i], TBL[4*c+i][11]);
                if (TBL[4*c+i][11])
                    chk(free_preg[i*6 +: 6] == TBL[4*c+i][5:0], "R5 free reg", free_preg[i*6 +: 6], TBL[4*c+i][5:0]);
            end
        end

        // Partial retirement stops at an unfinished entry (tags 16..19).
        alloc_fn(4, 16);
        complete(19, 4'b0000, "R4 young done only");
        complete(17, 4'b0000, "R4 head unfinished");
        complete(16, 4'b0000, "R4 not yet set");
        idle_grad(4'b0011, "R4 stop at tag 18");
        chk(free_valid == {2'b00, f_hd(17), f_hd(16)}, "R5 partial flags", free_valid, {f_hd(17), f_hd(16)});
        chk(free_preg[11:0] == {f_op(17), f_op(16)}, "R5 partial regs", free_preg[11:0], {f_op(17), f_op(16)});
        idle_grad(4'b0000, "R4 waiting on tag 18");
        complete(18, 4'b0000, "R4 completion latency");
        idle_grad(4'b0011, "R4 tags 18 and 19");

        // Fill to 29 entries across the wrap; full stall.
        for (int c = 0; c < 7; c++) alloc_fn(4, (20 + 4*c) % 32);
        alloc_fn(1, 16);
        @(negedge clk); clear_in();
        alloc_n = 3'd4;
        for (int i = 0; i < 4; i++) set_lane(i, 1'b1, 5'd1, 6'd1);
        #1;
        chk(alloc_ok == 1'b0, "R3 three free slots", alloc_ok, 0);
        @(negedge clk); clear_in();
        #1;
        chk(alloc_tag == 5'd17, "R3 request ignored", alloc_tag, 17);
        complete(14, 4'b0000, "R4 young completion");

        // Exception on tag 13: walk 16,15,14,13; recovery inputs ignored.
        @(negedge clk); clear_in();
        exc_valid = 1'b1; exc_tag = 5'd13;
        #1;
        chk(grad_mask == '0 && alloc_ok == 1'b0, "R6 exception cycle", {grad_mask, alloc_ok}, 0);
        for (int k = 0; k < 4; k++) begin
            int t;
            t = 16 - k;
            @(negedge clk); clear_in();
            if (k == 1) begin br_valid = 1'b1; br_tag = 5'd20; end
            if (k == 2) begin exc_valid = 1'b1; exc_tag = 5'd20; end
            #1;
            chk(undo_valid == f_hd(t), "R6 undo flag", undo_valid, f_hd(t));
            if (f_hd(t)) begin
                chk(undo_lreg == f_lr(t), "R6 undo lreg", undo_lreg, f_lr(t));
                chk(undo_preg == f_op(t), "R6 undo preg", undo_preg, f_op(t));
            end
            chk(alloc_ok == 1'b0 && grad_mask == '0, "R9 frozen during walk", {alloc_ok, grad_mask}, 0);
        end
        @(negedge clk); clear_in();
        #1;
        chk(undo_valid == 1'b0 && alloc_ok == 1'b1, "R7 walk finished", {undo_valid, alloc_ok}, 1);
        chk(alloc_tag == 5'd13, "R7 R9 tail at faulting tag", alloc_tag, 13);

        sum = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk); clear_in();
            cmpl_valid = 1'b1; cmpl_tag = 5'((20 + i) % 32);
            #1;
            sum += $countones(grad_mask);
        end
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); clear_in();
            #1;
            sum += $countones(grad_mask);
        end
        chk(sum == 25, "R7 only older entries retire", sum, 25);
        chk(alloc_tag == 5'd13 && alloc_ok == 1'b1, "R7 list empty", alloc_tag, 13);

        // Mispredict at tag 15 among tags 13..20.
        alloc_fn(4, 13);
        alloc_fn(4, 17);
        @(negedge clk); clear_in();
        br_valid = 1'b1; br_tag = 5'd15; alloc_n = 3'd4;
        #1;
        chk(alloc_ok == 1'b0 && grad_mask == '0, "R8 branch cycle", {alloc_ok, grad_mask}, 0);
        @(negedge clk); clear_in();
        #1;
        chk(alloc_tag == 5'd16, "R8 tail cut", alloc_tag, 16);
        complete(17, 4'b0000, "R8 squashed completion");
        complete(16, 4'b0000, "R8 squashed completion");
        complete(15, 4'b0000, "R8 waiting");
        complete(14, 4'b0000, "R8 waiting");
        complete(13, 4'b0000, "R8 waiting");
        idle_grad(4'b0111, "R8 retire stops at tail");
        idle_grad(4'b0000, "R8 list drained");
        chk(alloc_tag == 5'd16, "R8 tail kept", alloc_tag, 16);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule